// File: doc/BRIEF.md
# Dual-loop synthesizer digital core

This block is the synchronous digital half of a two-loop frequency synthesizer. Both loops run from one oscillator clock. Each loop has its own reference divider and its own feedback divider, and a third reference divider can stand in for either loop's reference. Each loop has a phase-frequency detector that issues digital "up" and "down" pulses for an external charge pump. The oscillator, prescaler, charge pump and loop filter sit outside the block. The block sees the divided-down oscillator signal of each loop as a single-cycle tick input that is synchronous to `clk`.

A host microcontroller loads every divide ratio and mode bit through a three-wire serial port: a shift clock, a data line and an active-low select. While select is low, bits are shifted in. When select rises, the word is committed. The block also drives a free-running clock for the host, which is the oscillator divided by 4 or by 3. It provides a lock indicator and a power-save mode. Power-save freezes the loops but leaves the host clock running.

Top module: `dual_synth_core`

## Requirements
- R1: While `rst_n` is low, `tx_up`, `tx_dn`, `rx_up`, `rx_dn`, `lock` and `host_clk` are all low. After reset, all five ratio registers hold 16 and every control bit is 0.
- R2: A serial word is 19 bits long and is sampled on rising `ser_clk` edges while `ser_sel_n` is low, MSB first. Its first 16 bits are data and its last 3 bits are an address. On the rising edge of `ser_sel_n` the data is written as follows: address 0 goes to the transmit reference ratio (12 bits), 1 to the receive reference ratio (12 bits), 2 to the auxiliary reference ratio (14 bits), 3 to the transmit feedback ratio, 4 to the receive feedback ratio, and 5 to the control register. Each ratio register takes the low bits of the data. Addresses 6 and 7 change nothing.
- R3: Each reference divider issues a one-cycle terminal pulse once every N oscillator cycles, where N is its ratio. A ratio below 16 acts as 16. A new ratio takes effect at the next reload.
- R4: Each feedback divider counts its loop's tick input and issues a one-cycle pulse on every Nth tick, with the same clamp to 16.
- R5: Each detector works on its loop's selected reference pulse and feedback pulse. A reference pulse sets up. A feedback pulse sets down. When both would be set, both clear. The outputs are registered, so they change one cycle after the divider pulse, and up and down are never high together.
- R6: Control bit 0 (transmit) and control bit 1 (receive) each replace that loop's own reference pulse with the auxiliary divider pulse.
- R7: `lock` goes high once 4 consecutive transmit-loop reference pulses pass with no error in either loop.
- R8: An error occurs when any detector output of either loop stays high for 4 or more consecutive cycles. An error clears the period count, and `lock` falls on the next cycle.
- R9: `host_clk` repeats high 2 and low 2 cycles when control bit 2 is 0, and high 1 and low 2 cycles when control bit 2 is 1.
- R10: While control bit 3 (power-save) is set, the dividers are held at reload, the detector outputs and `lock` are low, and `host_clk` keeps running. Releasing power-save restarts all dividers in phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_sel_n | input | 1 | Serial select, low while shifting, rising edge commits |
| tx_fb_tick | input | 1 | Transmit-loop divided signal tick |
| rx_fb_tick | input | 1 | Receive-loop divided signal tick |
| tx_up | output | 1 | Transmit detector up pulse |
| tx_dn | output | 1 | Transmit detector down pulse |
| rx_up | output | 1 | Receive detector up pulse |
| rx_dn | output | 1 | Receive detector down pulse |
| lock | output | 1 | Both loops locked |
| host_clk | output | 1 | Host clock, oscillator divided by 4 or 3 |

## Verification
The first pattern feeds ticks on every cycle with equal ratios, so reference and feedback pulses coincide and the bench can check that coincident pulses cancel and that lock asserts. A mismatched feedback ratio makes the pulses drift apart, which separates growing error pulses from tolerated narrow ones and shows that lock drops. A sub-minimum ratio, a write to an unused address, auxiliary substitution on the receive loop and ticks on every other cycle each give a lock result that a wrong clamp, a wrong decode or a wrong selection would change. The host clock is measured in both divide modes and during power-save.

// File: rtl/synth_pkg.sv
package synth_pkg;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = DATA_W + ADDR_W;
    localparam int MIN_DIV = 16;

    localparam logic [ADDR_W-1:0] SEL_TX_REF = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_RX_REF = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_AUX    = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_TX_FB  = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_RX_FB  = 3'd4;
    localparam logic [ADDR_W-1:0] SEL_MODE   = 3'd5;

    typedef struct packed {
        logic pwr_save;
        logic host_div3;
        logic rx_aux;
        logic tx_aux;
    } mode_t;
endpackage

// File: rtl/synth_serial_port.sv
module synth_serial_port
    import synth_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int AUX_W = 14,
    parameter int FB_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_sel_n,
    output logic [REF_W-1:0] tx_ref_ratio,
    output logic [REF_W-1:0] rx_ref_ratio,
    output logic [AUX_W-1:0] aux_ratio,
    output logic [FB_W-1:0]  tx_fb_ratio,
    output logic [FB_W-1:0]  rx_fb_ratio,
    output mode_t            mode
);
    typedef struct packed {
        logic              sclk;
        logic              sel;
        logic [WORD_W-1:0] sr;
        logic [REF_W-1:0]  tx_ref;
        logic [REF_W-1:0]  rx_ref;
        logic [AUX_W-1:0]  aux;
        logic [FB_W-1:0]   tx_fb;
        logic [FB_W-1:0]   rx_fb;
        mode_t             mode;
    } sp_t;

    sp_t s_d, s_q;
    logic [DATA_W-1:0] word_data;
    logic [ADDR_W-1:0] word_addr;

    assign word_data = s_q.sr[WORD_W-1:ADDR_W];
    assign word_addr = s_q.sr[ADDR_W-1:0];

    always_comb begin
        s_d      = s_q;
        s_d.sclk = ser_clk;
        s_d.sel  = ser_sel_n;
        if (!ser_sel_n && ser_clk && !s_q.sclk)
            s_d.sr = {s_q.sr[WORD_W-2:0], ser_dat};
        if (ser_sel_n && !s_q.sel) begin
            case (word_addr)
                SEL_TX_REF: s_d.tx_ref = word_data[REF_W-1:0];
                SEL_RX_REF: s_d.rx_ref = word_data[REF_W-1:0];
                SEL_AUX:    s_d.aux    = word_data[AUX_W-1:0];
                SEL_TX_FB:  s_d.tx_fb  = word_data[FB_W-1:0];
                SEL_RX_FB:  s_d.rx_fb  = word_data[FB_W-1:0];
                SEL_MODE:   s_d.mode   = word_data[$bits(mode_t)-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sclk   <= 1'b0;
            s_q.sel    <= 1'b1;
            s_q.sr     <= '0;
            s_q.tx_ref <= REF_W'(MIN_DIV);
            s_q.rx_ref <= REF_W'(MIN_DIV);
            s_q.aux    <= AUX_W'(MIN_DIV);
            s_q.tx_fb  <= FB_W'(MIN_DIV);
            s_q.rx_fb  <= FB_W'(MIN_DIV);
            s_q.mode   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_ref_ratio = s_q.tx_ref;
    assign rx_ref_ratio = s_q.rx_ref;
    assign aux_ratio    = s_q.aux;
    assign tx_fb_ratio  = s_q.tx_fb;
    assign rx_fb_ratio  = s_q.rx_fb;
    assign mode         = s_q.mode;

    // R2
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ser_sel_n) |-> $stable(s_q.sr));
endmodule

// File: rtl/synth_divider.sv
module synth_divider
    import synth_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         ev,
    input  logic [W-1:0] ratio,
    output logic         tc
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tc;
    } dv_t;

    dv_t d_d, d_q;
    logic [W-1:0] eff;

    assign eff = (ratio < W'(MIN_DIV)) ? W'(MIN_DIV) : ratio;

    always_comb begin
        d_d    = d_q;
        d_d.tc = 1'b0;
        if (hold) begin
            d_d.cnt = eff - 1'b1;
        end else if (ev) begin
            if (d_q.cnt == '0) begin
                d_d.tc  = 1'b1;
                d_d.cnt = eff - 1'b1;
            end else begin
                d_d.cnt = d_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q.cnt <= W'(MIN_DIV - 1);
            d_q.tc  <= 1'b0;
        end else begin
            d_q <= d_d;
        end
    end

    assign tc = d_q.tc;

    // R3
    tc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    // R4
    tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> $past(ev && !hold));
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ref_p,
    input  logic fb_p,
    output logic up,
    output logic dn
);
    typedef struct packed {
        logic up;
        logic dn;
    } pf_t;

    pf_t p_d, p_q;
    logic u_n, d_n;

    assign u_n = p_q.up | ref_p;
    assign d_n = p_q.dn | fb_p;

    always_comb begin
        p_d = p_q;
        if (hold || (u_n && d_n)) begin
            p_d.up = 1'b0;
            p_d.dn = 1'b0;
        end else begin
            p_d.up = u_n;
            p_d.dn = d_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign up = p_q.up;
    assign dn = p_q.dn;

    // R5
    pfd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));
    // R10
    pfd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!up && !dn));
endmodule

// File: rtl/synth_lock.sv
module synth_lock #(
    parameter int LOOPS  = 2,
    parameter int WIN    = 4,
    parameter int LOCK_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [LOOPS-1:0] up,
    input  logic [LOOPS-1:0] dn,
    input  logic             ref_p,
    output logic             lock
);
    localparam int WC_W = $clog2(WIN + 1);
    localparam int LC_W = $clog2(LOCK_N + 1);

    typedef struct packed {
        logic [LOOPS-1:0][WC_W-1:0] wcnt;
        logic [LC_W-1:0]            lcnt;
        logic                       lock;
    } lk_t;

    lk_t l_d, l_q;
    logic [LOOPS-1:0] wide;
    logic             err;

    for (genvar l = 0; l < LOOPS; l++) begin : g_wide
        assign wide[l] = (up[l] | dn[l]) && (l_q.wcnt[l] >= WC_W'(WIN - 1));
    end
    assign err = |wide;

    always_comb begin
        l_d = l_q;
        for (int l = 0; l < LOOPS; l++) begin
            if (hold || !(up[l] | dn[l]))
                l_d.wcnt[l] = '0;
            else if (l_q.wcnt[l] != WC_W'(WIN))
                l_d.wcnt[l] = l_q.wcnt[l] + 1'b1;
        end
        if (hold || err)
            l_d.lcnt = '0;
        else if (ref_p && l_q.lcnt != LC_W'(LOCK_N))
            l_d.lcnt = l_q.lcnt + 1'b1;
        l_d.lock = !hold && !err && (l_d.lcnt == LC_W'(LOCK_N));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign lock = l_q.lock;

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ref_p));
    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !lock);
endmodule

// File: rtl/dual_synth_core.sv
module dual_synth_core
    import synth_pkg::*;
#(
    parameter int REF_W  = 12,
    parameter int AUX_W  = 14,
    parameter int FB_W   = 16,
    parameter int WIN    = 4,
    parameter int LOCK_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic ser_sel_n,
    input  logic tx_fb_tick,
    input  logic rx_fb_tick,
    output logic tx_up,
    output logic tx_dn,
    output logic rx_up,
    output logic rx_dn,
    output logic lock,
    output logic host_clk
);
    localparam int LOOPS = 2;

    logic [REF_W-1:0] ref_ratio [LOOPS];
    logic [FB_W-1:0]  fb_ratio  [LOOPS];
    logic [AUX_W-1:0] aux_ratio;
    mode_t            mode;
    logic [LOOPS-1:0] own_tc, fb_tc, ref_sel, tick, use_aux, up, dn;
    logic             aux_tc;

    synth_serial_port #(.REF_W(REF_W), .AUX_W(AUX_W), .FB_W(FB_W)) u_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_sel_n(ser_sel_n), .tx_ref_ratio(ref_ratio[0]),
        .rx_ref_ratio(ref_ratio[1]), .aux_ratio(aux_ratio),
        .tx_fb_ratio(fb_ratio[0]), .rx_fb_ratio(fb_ratio[1]), .mode(mode)
    );

    synth_divider #(.W(AUX_W)) u_aux_div (
        .clk(clk), .rst_n(rst_n), .hold(mode.pwr_save), .ev(1'b1),
        .ratio(aux_ratio), .tc(aux_tc)
    );

    assign tick    = {rx_fb_tick, tx_fb_tick};
    assign use_aux = {mode.rx_aux, mode.tx_aux};

    for (genvar l = 0; l < LOOPS; l++) begin : g_loop
        synth_divider #(.W(REF_W)) u_ref_div (
            .clk(clk), .rst_n(rst_n), .hold(mode.pwr_save), .ev(1'b1),
            .ratio(ref_ratio[l]), .tc(own_tc[l])
        );
        synth_divider #(.W(FB_W)) u_fb_div (
            .clk(clk), .rst_n(rst_n), .hold(mode.pwr_save), .ev(tick[l]),
            .ratio(fb_ratio[l]), .tc(fb_tc[l])
        );
        assign ref_sel[l] = use_aux[l] ? aux_tc : own_tc[l];
        synth_pfd u_pfd (
            .clk(clk), .rst_n(rst_n), .hold(mode.pwr_save),
            .ref_p(ref_sel[l]), .fb_p(fb_tc[l]), .up(up[l]), .dn(dn[l])
        );
    end

    synth_lock #(.LOOPS(LOOPS), .WIN(WIN), .LOCK_N(LOCK_N)) u_lock (
        .clk(clk), .rst_n(rst_n), .hold(mode.pwr_save), .up(up), .dn(dn),
        .ref_p(ref_sel[0]), .lock(lock)
    );

    assign tx_up = up[0];
    assign tx_dn = dn[0];
    assign rx_up = up[1];
    assign rx_dn = dn[1];

    typedef struct packed {
        logic [1:0] cnt;
        logic       clk_o;
    } hc_t;

    hc_t h_d, h_q;
    logic [1:0] h_last;

    assign h_last = mode.host_div3 ? 2'd2 : 2'd3;

    always_comb begin
        h_d       = h_q;
        h_d.cnt   = (h_q.cnt >= h_last) ? 2'd0 : h_q.cnt + 2'd1;
        h_d.clk_o = mode.host_div3 ? (h_d.cnt == 2'd0) : (h_d.cnt < 2'd2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign host_clk = h_q.clk_o;

    // R9
    host_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clk && $past(host_clk)) |=> !host_clk);
endmodule

// File: tb/dual_synth_core_bench.sv
module dual_synth_core_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_sel_n = 1'b1;
    logic tx_fb_tick = 1'b0, rx_fb_tick = 1'b0;
    logic tx_up, tx_dn, rx_up, rx_dn, lock, host_clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int tick_mode = 0;
    bit lock_fell = 1'b0;

    always #2 clk = ~clk;

    dual_synth_core u_dual_synth_core (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_sel_n(ser_sel_n), .tx_fb_tick(tx_fb_tick), .rx_fb_tick(rx_fb_tick),
        .tx_up(tx_up), .tx_dn(tx_dn), .rx_up(rx_up), .rx_dn(rx_dn),
        .lock(lock), .host_clk(host_clk)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_ratio[5];
    int m_cnt[5];
    bit m_tc[5];
    int m_mode, m_sr, m_hcnt;
    bit m_sclk, m_sel, m_hclk, m_lock;
    bit m_up[2], m_dn[2];
    int m_w[2], m_lcnt;
    int masks[5] = '{4095, 4095, 16383, 65535, 65535};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin
                m_ratio[i] = 16; m_cnt[i] = 15; m_tc[i] = 0;
            end
            m_mode = 0; m_sr = 0; m_hcnt = 0; m_sclk = 0; m_sel = 1;
            m_hclk = 0; m_lock = 0; m_lcnt = 0;
            for (int l = 0; l < 2; l++) begin m_up[l] = 0; m_dn[l] = 0; m_w[l] = 0; end
        end else begin
            bit ps, err, u, d;
            bit rp[2];
            int n, eff;
            bit ev;
            ps = m_mode[3];
            rp[0] = m_mode[0] ? m_tc[2] : m_tc[0];
            rp[1] = m_mode[1] ? m_tc[2] : m_tc[1];
            err = 0;
            for (int l = 0; l < 2; l++) begin
                if ((m_up[l] || m_dn[l]) && m_w[l] >= 3) err = 1;
                if (ps || !(m_up[l] || m_dn[l])) m_w[l] = 0;
                else if (m_w[l] < 4) m_w[l]++;
            end
            if (ps || err) m_lcnt = 0;
            else if (rp[0] && m_lcnt < 4) m_lcnt++;
            m_lock = !ps && !err && (m_lcnt == 4);
            for (int l = 0; l < 2; l++) begin
                u = m_up[l] || rp[l];
                d = m_dn[l] || m_tc[3+l];
                if (ps || (u && d)) begin m_up[l] = 0; m_dn[l] = 0; end
                else begin m_up[l] = u; m_dn[l] = d; end
            end
            for (int i = 0; i < 5; i++) begin
                ev = (i < 3) ? 1'b1 : ((i == 3) ? tx_fb_tick : rx_fb_tick);
                eff = (m_ratio[i] < 16) ? 16 : m_ratio[i];
                m_tc[i] = 0;
                if (ps) m_cnt[i] = eff - 1;
                else if (ev) begin
                    if (m_cnt[i] == 0) begin m_tc[i] = 1; m_cnt[i] = eff - 1; end
                    else m_cnt[i]--;
                end
            end
            n = m_mode[2] ? 3 : 4;
            m_hcnt = (m_hcnt >= n - 1) ? 0 : m_hcnt + 1;
            m_hclk = (m_hcnt < n / 2);
            if (!ser_sel_n && ser_clk && !m_sclk) m_sr = ((m_sr << 1) | ser_dat) & 32'h7FFFF;
            if (ser_sel_n && !m_sel) begin
                int a, dt;
                a = m_sr & 7; dt = m_sr >> 3;
                if (a < 5) m_ratio[a] = dt & masks[a];
                else if (a == 5) m_mode = dt & 15;
            end
            m_sclk = ser_clk; m_sel = ser_sel_n;
        end
    end

    // per-cycle comparison and tick stimulus, both at the falling edge
    int phase = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 tx_up", tx_up, m_up[0]);
            check("R5 tx_dn", tx_dn, m_dn[0]);
            check("R5 rx_up", rx_up, m_up[1]);
            check("R5 rx_dn", rx_dn, m_dn[1]);
            check("R7 lock", lock, m_lock);
            check("R9 host_clk", host_clk, m_hclk);
            if (!lock && $past(lock)) lock_fell = 1'b1;
        end
        phase++;
        tx_fb_tick <= (tick_mode == 0) ? 1'b1 : phase[0];
        rx_fb_tick <= 1'b1;
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(int addr, int data);
        logic [18:0] w;
        w = {data[15:0], addr[2:0]};
        @(negedge clk);
        ser_sel_n = 1'b0;
        for (int i = 18; i >= 0; i--) begin
            ser_dat = w[i];
            ser_clk = 1'b0; wait_cyc(2);
            ser_clk = 1'b1; wait_cyc(2);
        end
        ser_clk = 1'b0; wait_cyc(2);
        ser_sel_n = 1'b1; wait_cyc(3);
    endtask

    task automatic count_high(string req, int exp);
        int h = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (host_clk) h++;
        end
        check(req, h, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tx_up", tx_up, 0);
        check("R1 tx_dn", tx_dn, 0);
        check("R1 rx_up", rx_up, 0);
        check("R1 rx_dn", rx_dn, 0);
        check("R1 lock", lock, 0);
        check("R1 host_clk", host_clk, 0);
        rst_n = 1'b1;
        // R1 default ratios 16 give coincident pulses and lock
        wait_cyc(120);
        check("R1 default lock", lock, 1);
        count_high("R9 div4 highs", 12);
        // R8 mismatched transmit feedback ratio
        lock_fell = 1'b0;
        send(3, 20);
        wait_cyc(300);
        check("R8 lock dropped", lock_fell, 1);
        // R3 ratio 5 clamps to 16; R10 power-save realigns
        send(3, 16);
        send(0, 5);
        send(5, 8);
        wait_cyc(2);
        check("R10 tx_up held", tx_up, 0);
        check("R10 rx_dn held", rx_dn, 0);
        check("R10 lock held", lock, 0);
        count_high("R10 host_clk runs", 12);
        send(5, 0);
        wait_cyc(120);
        check("R3 clamp lock", lock, 1);
        // R2 address 7 ignored
        send(7, 20);
        wait_cyc(120);
        check("R2 addr7 ignored", lock, 1);
        // R6 receive loop on auxiliary divider
        send(2, 48);
        send(4, 48);
        send(5, 8 + 2);
        send(5, 2);
        wait_cyc(300);
        check("R6 aux lock", lock, 1);
        // R4 transmit ticks every other cycle, ref 32 vs fb 16
        send(0, 32);
        send(5, 8 + 2);
        tick_mode = 1;
        wait_cyc(4);
        send(5, 2);
        wait_cyc(400);
        check("R4 half-rate lock", lock, 1);
        // R9 divide by 3
        send(5, 4 + 2);
        wait_cyc(4);
        count_high("R9 div3 highs", 8);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule